// File: doc/BRIEF.md
# Straddled Packet Boundary Tracker

This block watches the sideband of a wide streaming request interface on which as many as four packets can begin or finish inside one 1024-bit beat. On such a link the end-of-packet strobe is tied low and every keep bit is high, so they say nothing about boundaries. The tracker frames packets from two other sources instead. One is a pair of thermometer-coded vectors that give the number of packet starts and packet ends in the beat. The other is the per-slot pointers that go with each of them.

For each accepted beat the block produces, one cycle later, the start and end slot vectors. It gives the byte lane where each packet begins and the Dword offset of each packet's last Dword. A per-end-slot discard flag marks packets that downstream logic must throw away. A state bit remembers whether a packet is still open across the beat boundary. Every beat is checked for reserved encodings and for framing faults. Either kind of fault produces a one-cycle error pulse and sets a sticky error flag. Two running counters tally packets that closed cleanly and packets that were dropped.

Top module: `straddle_frame_tracker`

## Requirements
- R1: A beat is taken only on a cycle where `i_valid` and `i_ready` are both high. One cycle later `o_valid` pulses. The event outputs, the open flag and the counters change only after a taken beat, and the event and error outputs are zero whenever `o_valid` is low.
- R2: The start vector must be one of 0000, 0001, 0011, 0111 or 1111. Any other value raises `o_enc_err` for that beat.
- R3: Start pointer k (2 bits per slot, slot k at bits [2k+1:2k]) may not hold a code below k. Within a beat the pointers of the valid start slots must strictly increase. A violation of either rule raises `o_enc_err`.
- R4: For each valid start slot, `o_sop_lane` gives byte lane 32 times the pointer code. For each valid end slot, `o_eop_dw` gives the 5-bit end pointer (slot k at bits [5k+4:5k]). Fields of slots that are not valid read zero.
- R5: The end vector uses the same thermometer code as the start vector. Any other value raises `o_enc_err`.
- R6: `o_open` is high after a beat if the number of starts plus the open flag from before the beat exceeds the number of ends.
- R7: `o_frm_err` is raised in four cases. (a) An end has no open packet and no earlier start in the beat to close. (b) A start arrives while the previous packet has no end before it. (c) An end offset lies below the Dword where its packet starts. (d) A start Dword (8 times the pointer code) does not lie strictly after the preceding end offset.
- R8: When the discontinue bit is set with end slot 0 valid, `o_discard[0]` is set. Discontinue with no end, or followed by another start in the same beat, raises `o_enc_err`.
- R9: Poison bit k marks the packet started by start slot k. That packet's end slot is discarded, even when the end arrives in a later beat. A poison bit on a slot with no start raises `o_enc_err`.
- R10: In a beat with any error, every valid end slot is discarded. `o_discard` is never set for a slot without an end. `o_err_sticky` stays high until reset.
- R11: `o_good_cnt` grows by the number of valid end slots that are not discarded, and `o_drop_cnt` by the number that are.
- R12: Reset clears every output, the open flag and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Beat valid on the monitored link |
| i_ready | input | 1 | Receiver ready on the monitored link |
| i_sop_vec | input | 4 | Thermometer-coded start slots |
| i_sop_ptr | input | 8 | Start pointer codes, 2 bits per slot |
| i_eop_vec | input | 4 | Thermometer-coded end slots |
| i_eop_ptr | input | 20 | End Dword offsets, 5 bits per slot |
| i_discontinue | input | 1 | Payload fault on the first packet ending in the beat |
| i_poison | input | 4 | Poison flag per start slot |
| o_valid | output | 1 | One-cycle pulse after each taken beat |
| o_sop_vld | output | 4 | Start slots of the reported beat |
| o_sop_lane | output | 28 | Start byte lane, 7 bits per slot |
| o_eop_vld | output | 4 | End slots of the reported beat |
| o_eop_dw | output | 20 | End Dword offset, 5 bits per slot |
| o_discard | output | 4 | Discard flag per end slot |
| o_enc_err | output | 1 | Reserved encoding seen in the reported beat |
| o_frm_err | output | 1 | Framing fault seen in the reported beat |
| o_err_sticky | output | 1 | Any error since reset |
| o_open | output | 1 | A packet remains open after the last taken beat |
| o_good_cnt | output | 16 | Packets closed without discard |
| o_drop_cnt | output | 16 | Packets closed with discard |

## Verification
A packet carried in from an earlier beat can close in the same beat in which new packets open. That single beat then moves the open flag, consumes the poison held for the carried packet and latches poison for the newest packet. The stimulus table drives several such beats: a carried end before two fresh starts, one with its last start left open and poisoned, and one where an end offset crosses the next start. Each is judged on the end offsets, the discard mask, the open flag of the following beat and the two counter totals.

// File: rtl/sft_pkg.sv
package sft_pkg;

  // population count over a vector of up to eight slots
  function automatic int unsigned f_ones(input logic [7:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  // true when v is 0, 1, 3, 7, 15, ... (a run of ones from bit 0)
  function automatic logic f_is_thermo(input logic [7:0] v);
    logic [8:0] full;
    full = (9'd1 << f_ones(v)) - 9'd1;
    return v == full[7:0];
  endfunction

  // byte lane addressed by a start pointer code
  function automatic int unsigned f_lane(input int unsigned code, input int unsigned step);
    return code * step;
  endfunction

  // first Dword of a start slot, given its pointer code
  function automatic int unsigned f_start_dw(input int unsigned code, input int unsigned step);
    return (code * step) / 4;
  endfunction

  typedef enum logic [1:0] {
    BEAT_CLEAN = 2'd0,
    BEAT_ENC   = 2'd1,
    BEAT_FRM   = 2'd2,
    BEAT_BOTH  = 2'd3
  } beat_status_e;

endpackage

// File: rtl/sft_decode.sv
module sft_decode
  import sft_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int PTR_W     = 2,
  parameter int OFF_W     = 5,
  parameter int LANE_W    = 7,
  parameter int LANE_STEP = 32
) (
  input  logic [SLOTS-1:0]                  sop_vec,
  input  logic [SLOTS-1:0][PTR_W-1:0]       sop_ptr,
  input  logic [SLOTS-1:0]                  eop_vec,
  input  logic [SLOTS-1:0]                  poison_vec,
  output logic [SLOTS-1:0][OFF_W-1:0]       sop_pos,
  output logic [SLOTS-1:0][LANE_W-1:0]      sop_lane,
  output logic                              enc_err
);

  logic              sop_thermo;
  logic              eop_thermo;
  logic [SLOTS-1:0]  ptr_low;
  logic [SLOTS-1:0]  ptr_order;
  logic              poison_orphan;

  assign sop_thermo    = f_is_thermo(8'(sop_vec));
  assign eop_thermo    = f_is_thermo(8'(eop_vec));
  assign poison_orphan = |(poison_vec & ~sop_vec);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign sop_pos[k]  = OFF_W'(f_start_dw(int'(sop_ptr[k]), LANE_STEP));
    assign sop_lane[k] = sop_vec[k] ? LANE_W'(f_lane(int'(sop_ptr[k]), LANE_STEP)) : '0;
    assign ptr_low[k]  = sop_vec[k] && (int'(sop_ptr[k]) < k);
    if (k == 0) begin : g_first
      assign ptr_order[k] = 1'b0;
    end else begin : g_rest
      assign ptr_order[k] = sop_vec[k] && sop_vec[k-1] && (sop_ptr[k] <= sop_ptr[k-1]);
    end
  end

  assign enc_err = !sop_thermo || !eop_thermo || (|ptr_low) || (|ptr_order) || poison_orphan;

endmodule

// File: rtl/sft_frame.sv
module sft_frame
  import sft_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int OFF_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic [SLOTS-1:0]             sop_vec,
  input  logic [SLOTS-1:0]             eop_vec,
  input  logic [SLOTS-1:0][OFF_W-1:0]  sop_pos,
  input  logic [SLOTS-1:0][OFF_W-1:0]  eop_off,
  input  logic [SLOTS-1:0]             poison_vec,
  input  logic                         disc,
  input  logic                         enc_err_in,
  output logic                         frm_err,
  output logic                         disc_bad,
  output logic                         beat_err,
  output logic [SLOTS-1:0]             discard,
  output logic                         open_q
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW    = $clog2(SLOTS + 1);

  logic             carry;
  logic [IDX_W-1:0] m_idx;
  logic [IDX_W-1:0] p_idx;
  logic [SLOTS-1:0] pz;
  logic [CW-1:0]    nsop;
  logic [CW-1:0]    neop;
  logic             open_d;
  logic             poison_q;
  logic             poison_d;

  assign carry = open_q;
  assign nsop  = CW'(f_ones(8'(sop_vec)));
  assign neop  = CW'(f_ones(8'(eop_vec)));

  // pair every end with the packet it closes, and every start with the end before it
  always_comb begin
    frm_err = 1'b0;
    pz      = '0;
    m_idx   = '0;
    p_idx   = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (carry && j == 0) begin
        pz[j] = poison_q;
      end else begin
        m_idx = IDX_W'(j - int'(carry));
        pz[j] = poison_vec[m_idx];
        if (eop_vec[j] && !sop_vec[m_idx]) frm_err = 1'b1;
        if (eop_vec[j] && sop_vec[m_idx] && (eop_off[j] < sop_pos[m_idx])) frm_err = 1'b1;
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (sop_vec[s] && (s > 0 || carry)) begin
        p_idx = IDX_W'(s - 1 + int'(carry));
        if (!eop_vec[p_idx] || (eop_off[p_idx] >= sop_pos[s])) frm_err = 1'b1;
      end
    end
  end

  assign open_d   = (int'(nsop) + int'(carry)) > int'(neop);
  assign poison_d = !open_d ? 1'b0 :
                    (nsop != '0) ? poison_vec[IDX_W'(nsop - CW'(1))] : poison_q;
  assign disc_bad = disc && (!eop_vec[0] || (int'(nsop) > (carry ? 0 : 1)));
  assign beat_err = enc_err_in || frm_err || disc_bad;

  for (genvar j = 0; j < SLOTS; j++) begin : g_drop
    if (j == 0) begin : g_first
      assign discard[j] = eop_vec[j] && (beat_err || pz[j] || disc);
    end else begin : g_rest
      assign discard[j] = eop_vec[j] && (beat_err || pz[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      poison_q <= 1'b0;
    end else if (accept) begin
      open_q   <= open_d;
      poison_q <= poison_d;
    end
  end

  AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(open_q) && $stable(poison_q)); // R1

  AST_POISON_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !poison_q); // R9

  AST_STRAY_END: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !open_q && (sop_vec == '0) && (eop_vec != '0) |-> frm_err); // R7

endmodule

// File: rtl/sft_count.sv
module sft_count
  import sft_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [SLOTS-1:0]  eop_vec,
  input  logic [SLOTS-1:0]  discard,
  output logic [CNT_W-1:0]  good,
  output logic [CNT_W-1:0]  drop
);

  logic [CNT_W-1:0] good_inc;
  logic [CNT_W-1:0] drop_inc;

  assign good_inc = CNT_W'(f_ones(8'(eop_vec & ~discard)));
  assign drop_inc = CNT_W'(f_ones(8'(discard)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good <= '0;
      drop <= '0;
    end else if (upd) begin
      good <= good + good_inc;
      drop <= drop + drop_inc;
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(good) && $stable(drop)); // R1

  AST_CNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> CNT_W'(good + drop) == CNT_W'($past(good) + $past(drop) + CNT_W'($past($countones(eop_vec))))); // R11

endmodule

// File: rtl/straddle_frame_tracker.sv
module straddle_frame_tracker
  import sft_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int PTR_W     = 2,
  parameter int OFF_W     = 5,
  parameter int LANE_STEP = 32,
  parameter int CNT_W     = 16,
  localparam int LANE_W   = $clog2(SLOTS * LANE_STEP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      i_valid,
  input  logic                      i_ready,
  input  logic [SLOTS-1:0]          i_sop_vec,
  input  logic [SLOTS*PTR_W-1:0]    i_sop_ptr,
  input  logic [SLOTS-1:0]          i_eop_vec,
  input  logic [SLOTS*OFF_W-1:0]    i_eop_ptr,
  input  logic                      i_discontinue,
  input  logic [SLOTS-1:0]          i_poison,
  output logic                      o_valid,
  output logic [SLOTS-1:0]          o_sop_vld,
  output logic [SLOTS*LANE_W-1:0]   o_sop_lane,
  output logic [SLOTS-1:0]          o_eop_vld,
  output logic [SLOTS*OFF_W-1:0]    o_eop_dw,
  output logic [SLOTS-1:0]          o_discard,
  output logic                      o_enc_err,
  output logic                      o_frm_err,
  output logic                      o_err_sticky,
  output logic                      o_open,
  output logic [CNT_W-1:0]          o_good_cnt,
  output logic [CNT_W-1:0]          o_drop_cnt
);

  logic                             accept;
  logic [SLOTS-1:0][PTR_W-1:0]      sop_ptr_a;
  logic [SLOTS-1:0][OFF_W-1:0]      eop_off_a;
  logic [SLOTS-1:0][OFF_W-1:0]      eop_off_m;
  logic [SLOTS-1:0][OFF_W-1:0]      sop_pos;
  logic [SLOTS-1:0][LANE_W-1:0]     sop_lane;
  logic                             enc_raw;
  logic                             frm_err;
  logic                             disc_bad;
  logic                             beat_err;
  logic [SLOTS-1:0]                 discard;
  beat_status_e                     status;

  assign accept    = i_valid && i_ready;
  assign sop_ptr_a = i_sop_ptr;
  assign eop_off_a = i_eop_ptr;

  for (genvar k = 0; k < SLOTS; k++) begin : g_eop
    assign eop_off_m[k] = i_eop_vec[k] ? eop_off_a[k] : '0;
  end

  sft_decode #(
    .SLOTS(SLOTS), .PTR_W(PTR_W), .OFF_W(OFF_W), .LANE_W(LANE_W), .LANE_STEP(LANE_STEP)
  ) u_decode (
    .sop_vec    (i_sop_vec),
    .sop_ptr    (sop_ptr_a),
    .eop_vec    (i_eop_vec),
    .poison_vec (i_poison),
    .sop_pos    (sop_pos),
    .sop_lane   (sop_lane),
    .enc_err    (enc_raw)
  );

  sft_frame #(.SLOTS(SLOTS), .OFF_W(OFF_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .sop_vec    (i_sop_vec),
    .eop_vec    (i_eop_vec),
    .sop_pos    (sop_pos),
    .eop_off    (eop_off_a),
    .poison_vec (i_poison),
    .disc       (i_discontinue),
    .enc_err_in (enc_raw),
    .frm_err    (frm_err),
    .disc_bad   (disc_bad),
    .beat_err   (beat_err),
    .discard    (discard),
    .open_q     (o_open)
  );

  sft_count #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (accept),
    .eop_vec (i_eop_vec),
    .discard (discard),
    .good    (o_good_cnt),
    .drop    (o_drop_cnt)
  );

  assign status = beat_status_e'({frm_err, enc_raw || disc_bad});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid      <= 1'b0;
      o_sop_vld    <= '0;
      o_sop_lane   <= '0;
      o_eop_vld    <= '0;
      o_eop_dw     <= '0;
      o_discard    <= '0;
      o_enc_err    <= 1'b0;
      o_frm_err    <= 1'b0;
      o_err_sticky <= 1'b0;
    end else begin
      o_valid <= accept;
      if (accept) begin
        o_sop_vld    <= i_sop_vec;
        o_sop_lane   <= sop_lane;
        o_eop_vld    <= i_eop_vec;
        o_eop_dw     <= eop_off_m;
        o_discard    <= discard;
        o_enc_err    <= (status == BEAT_ENC) || (status == BEAT_BOTH);
        o_frm_err    <= (status == BEAT_FRM) || (status == BEAT_BOTH);
        o_err_sticky <= o_err_sticky || beat_err;
      end else begin
        o_sop_vld  <= '0;
        o_sop_lane <= '0;
        o_eop_vld  <= '0;
        o_eop_dw   <= '0;
        o_discard  <= '0;
        o_enc_err  <= 1'b0;
        o_frm_err  <= 1'b0;
      end
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid && !i_ready |=> i_valid && $stable(i_sop_vec) && $stable(i_eop_vec) && $stable(i_sop_ptr) && $stable(i_eop_ptr)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> (o_sop_vld == '0) && (o_eop_vld == '0) && !o_enc_err && !o_frm_err); // R1

  AST_SOP_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !f_is_thermo(8'(i_sop_vec)) |=> o_enc_err); // R2

  AST_EOP_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !f_is_thermo(8'(i_eop_vec)) |=> o_enc_err); // R5

  AST_DISC_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && i_discontinue && i_eop_vec[0] |=> o_discard[0]); // R8

  AST_DISCARD_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (o_discard & ~o_eop_vld) == '0); // R10

  AST_ERR_DROP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && (o_enc_err || o_frm_err) |-> (o_discard == o_eop_vld)); // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_err_sticky |=> o_err_sticky); // R10

endmodule

// File: tb/straddle_frame_tracker_bench.sv
`timescale 1ns/1ps
module straddle_frame_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_valid = 1'b0, i_ready = 1'b0, i_discontinue = 1'b0;
  logic [3:0]  i_sop_vec = '0, i_eop_vec = '0, i_poison = '0;
  logic [7:0]  i_sop_ptr = '0;
  logic [19:0] i_eop_ptr = '0;
  logic        o_valid, o_enc_err, o_frm_err, o_err_sticky, o_open;
  logic [3:0]  o_sop_vld, o_eop_vld, o_discard;
  logic [27:0] o_sop_lane;
  logic [19:0] o_eop_dw;
  logic [15:0] o_good_cnt, o_drop_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic exp_sticky = 1'b0;

  always #2 clk = ~clk;

  straddle_frame_tracker u_straddle_frame_tracker (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready),
    .i_sop_vec(i_sop_vec), .i_sop_ptr(i_sop_ptr), .i_eop_vec(i_eop_vec),
    .i_eop_ptr(i_eop_ptr), .i_discontinue(i_discontinue), .i_poison(i_poison),
    .o_valid(o_valid), .o_sop_vld(o_sop_vld), .o_sop_lane(o_sop_lane),
    .o_eop_vld(o_eop_vld), .o_eop_dw(o_eop_dw), .o_discard(o_discard),
    .o_enc_err(o_enc_err), .o_frm_err(o_frm_err), .o_err_sticky(o_err_sticky),
    .o_open(o_open), .o_good_cnt(o_good_cnt), .o_drop_cnt(o_drop_cnt)
  );

  typedef struct packed {
    logic [3:0]  sop;
    logic [7:0]  sptr;
    logic [3:0]  eop;
    logic [19:0] eptr;
    logic        disc;
    logic [3:0]  pois;
    logic [3:0]  x_disc;
    logic        x_enc;
    logic        x_frm;
    logic        x_open;
    logic [15:0] x_good;
    logic [15:0] x_drop;
  } row_t;

  localparam int NROW = 18;
  localparam row_t ROWS [NROW] = '{
    '{4'b0001, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd7},    1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 16'd1,  16'd0},
    '{4'b0011, 8'b00001000,  4'b0011, {5'd0,5'd0,5'd20,5'd5},   1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 16'd3,  16'd0},
    '{4'b0001, 8'b00000001,  4'b0000, 20'd0,                    1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 16'd3,  16'd0},
    '{4'b0000, 8'h00,        4'b0000, 20'd0,                    1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 16'd3,  16'd0},
    '{4'b0011, 8'b00001101,  4'b0011, {5'd0,5'd0,5'd12,5'd3},   1'b0, 4'b0010, 4'b0000, 1'b0, 1'b0, 1'b1, 16'd5,  16'd0},
    '{4'b0000, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd31},   1'b0, 4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, 16'd5,  16'd1},
    '{4'b0001, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd10},   1'b1, 4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, 16'd5,  16'd2},
    '{4'b0000, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd4},    1'b0, 4'b0000, 4'b0001, 1'b0, 1'b1, 1'b0, 16'd5,  16'd3},
    '{4'b0000, 8'h00,        4'b0010, {5'd0,5'd0,5'd9,5'd0},    1'b0, 4'b0000, 4'b0010, 1'b1, 1'b1, 1'b0, 16'd5,  16'd4},
    '{4'b0011, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd3},    1'b0, 4'b0000, 4'b0001, 1'b1, 1'b1, 1'b1, 16'd5,  16'd5},
    '{4'b0000, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd0},    1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 16'd6,  16'd5},
    '{4'b0001, 8'b00000010,  4'b0001, {5'd0,5'd0,5'd0,5'd20},   1'b0, 4'b0010, 4'b0001, 1'b1, 1'b0, 1'b0, 16'd6,  16'd6},
    '{4'b0000, 8'h00,        4'b0000, 20'd0,                    1'b1, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 16'd6,  16'd6},
    '{4'b0011, 8'b00001000,  4'b0001, {5'd0,5'd0,5'd0,5'd5},    1'b1, 4'b0000, 4'b0001, 1'b1, 1'b0, 1'b1, 16'd6,  16'd7},
    '{4'b0001, 8'h00,        4'b0000, 20'd0,                    1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 16'd6,  16'd7},
    '{4'b0011, 8'b00001001,  4'b0011, {5'd0,5'd0,5'd17,5'd2},   1'b0, 4'b0000, 4'b0011, 1'b0, 1'b1, 1'b1, 16'd6,  16'd9},
    '{4'b0000, 8'h00,        4'b0001, {5'd0,5'd0,5'd0,5'd31},   1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 16'd7,  16'd9},
    '{4'b1111, 8'b11100100,  4'b1111, {5'd30,5'd17,5'd9,5'd1},  1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 16'd11, 16'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic r, input logic [3:0] sop, input logic [7:0] sptr,
                       input logic [3:0] eop, input logic [19:0] eptr, input logic disc, input logic [3:0] pois);
    @(negedge clk);
    i_valid = v; i_ready = r; i_sop_vec = sop; i_sop_ptr = sptr;
    i_eop_vec = eop; i_eop_ptr = eptr; i_discontinue = disc; i_poison = pois;
    @(posedge clk);
    #1;
  endtask

  // lane in bytes: pointer code shifted into the 32-byte position
  function automatic logic [27:0] exp_lanes(input logic [3:0] sop, input logic [7:0] sptr);
    logic [27:0] r;
    r = '0;
    for (int k = 0; k < 4; k++)
      if (sop[k]) r[k*7 +: 7] = {sptr[k*2 +: 2], 5'b00000};
    return r;
  endfunction

  function automatic logic [19:0] exp_offs(input logic [3:0] eop, input logic [19:0] eptr);
    logic [19:0] r;
    r = '0;
    for (int k = 0; k < 4; k++)
      if (eop[k]) r[k*5 +: 5] = eptr[k*5 +: 5];
    return r;
  endfunction

  task automatic check_reset_state();
    chk("R12 valid",   32'(o_valid), 0);
    chk("R12 events",  32'({o_sop_vld, o_eop_vld, o_discard}), 0);
    chk("R12 errors",  32'({o_enc_err, o_frm_err, o_err_sticky}), 0);
    chk("R12 open",    32'(o_open), 0);
    chk("R12 counts",  {o_good_cnt, o_drop_cnt}, 0);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      drive(1'b1, 1'b1, ROWS[i].sop, ROWS[i].sptr, ROWS[i].eop, ROWS[i].eptr, ROWS[i].disc, ROWS[i].pois);
      exp_sticky = exp_sticky | ROWS[i].x_enc | ROWS[i].x_frm;
      chk($sformatf("R1 row%0d valid pulse", i), 32'(o_valid), 1);
      chk($sformatf("R2 R5 row%0d slot vectors", i), 32'({o_sop_vld, o_eop_vld}), 32'({ROWS[i].sop, ROWS[i].eop}));
      chk($sformatf("R4 row%0d start lanes", i), 32'(o_sop_lane), 32'(exp_lanes(ROWS[i].sop, ROWS[i].sptr)));
      chk($sformatf("R4 row%0d end offsets", i), 32'(o_eop_dw), 32'(exp_offs(ROWS[i].eop, ROWS[i].eptr)));
      chk($sformatf("R2 R3 R5 R8 R9 row%0d encoding error", i), 32'(o_enc_err), 32'(ROWS[i].x_enc));
      chk($sformatf("R7 row%0d framing error", i), 32'(o_frm_err), 32'(ROWS[i].x_frm));
      chk($sformatf("R8 R9 R10 row%0d discard", i), 32'(o_discard), 32'(ROWS[i].x_disc));
      chk($sformatf("R6 row%0d open flag", i), 32'(o_open), 32'(ROWS[i].x_open));
      chk($sformatf("R11 row%0d good count", i), 32'(o_good_cnt), 32'(ROWS[i].x_good));
      chk($sformatf("R11 row%0d drop count", i), 32'(o_drop_cnt), 32'(ROWS[i].x_drop));
      chk($sformatf("R10 row%0d sticky", i), 32'(o_err_sticky), 32'(exp_sticky));
    end

    // R1: stalled beat is not taken until ready rises
    for (int c = 0; c < 3; c++) begin
      drive(1'b1, 1'b0, 4'b0001, 8'h00, 4'b0001, 20'd3, 1'b0, 4'b0000);
      chk("R1 stalled no pulse", 32'(o_valid), 0);
      chk("R1 stalled no count", 32'(o_good_cnt), 11);
    end
    drive(1'b1, 1'b1, 4'b0001, 8'h00, 4'b0001, 20'd3, 1'b0, 4'b0000);
    chk("R1 released pulse", 32'(o_valid), 1);
    chk("R1 released count", 32'(o_good_cnt), 12);

    // R1: flags without valid are ignored
    drive(1'b0, 1'b1, 4'b0101, 8'hff, 4'b1111, 20'hfffff, 1'b1, 4'b1111);
    chk("R1 idle no pulse", 32'(o_valid), 0);
    chk("R1 idle no events", 32'({o_sop_vld, o_eop_vld, o_enc_err, o_frm_err}), 0);
    drive(1'b0, 1'b0, 4'b0001, 8'h00, 4'b0000, 20'd0, 1'b0, 4'b0000);
    chk("R1 idle open kept", 32'(o_open), 0);
    chk("R1 idle counts kept", {o_good_cnt, o_drop_cnt}, {16'd12, 16'd9});

    // R12: reset clears state and sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;

    // R10: one bad beat, then clean beats keep the sticky flag but not the pulse
    drive(1'b1, 1'b1, 4'b1011, 8'h00, 4'b0000, 20'd0, 1'b0, 4'b0000);
    chk("R2 reserved start code", 32'(o_enc_err), 1);
    drive(1'b1, 1'b1, 4'b0001, 8'h00, 4'b0001, 20'd2, 1'b0, 4'b0000);
    chk("R10 pulse cleared", 32'(o_enc_err), 0);
    chk("R10 sticky held", 32'(o_err_sticky), 1);
    drive(1'b0, 1'b0, 4'b0000, 8'h00, 4'b0000, 20'd0, 1'b0, 4'b0000);
    chk("R10 sticky held idle", 32'(o_err_sticky), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule